// File: doc/BRIEF.md
# Port Suspend-Resume Blanking Controller

This block follows the functional state of a USB host controller and the suspend state of every root hub port. It enforces a quiet period after a resume. During that period, responses that downstream devices send upstream are thrown away. Packets going downstream are still sent, because the gates that allow list processing do not depend on the quiet period.

The controller-wide window opens when the controller moves from its resume state into its operational state. A per-port window opens when resume signalling on that port's segment finishes. Each window lasts a fixed number of 1 ms frame ticks. Any response that lands inside a window, or that comes from a port that is not active, is marked as ignored and given the Device Not Responding completion code.

A port reports that it has left suspend only when its window closes. At that moment it clears its suspend bit and raises a sticky change bit. Software clears the change bit by writing 1 to it. A maskable interrupt is raised while any change bit is set.

Top module: `port_resume_blank`

## Requirements
- R1: After reset, `hc_state` is 2'b00 (reset), every `pss` bit is 0, every `pssc` bit is 0 and `irq` is 0.
- R2: The controller state uses these encodings: 00 reset, 01 resume, 10 operational, 11 suspend. A `state_wr_valid` pulse loads `state_wr_val` on the next cycle. Without a write, `ctl_wakeup` moves suspend to resume, and `ctl_rsm_done` moves resume to operational. In any other state, each of these two inputs has no effect.
- R3: When the controller enters operational from resume, a controller blanking window opens. The window closes on the clock edge that samples the BLANK_TICKS-th `frame_tick` after entry. A tick in the same cycle as the entry is not counted. A write of any state other than operational closes the window at once.
- R4: A response is dropped when it arrives while `hc_state` is not operational or a blanking window is open. A dropped response drives `rsp_drop`=1 and `rsp_cc`=4'h5. An accepted response, or a cycle with no response, drives `rsp_drop`=0 and `rsp_cc`=4'h0. The decision does not depend on which list issued the transaction.
- R5: `port_susp_req` on an active port sets its `pss` on the next cycle. On a suspended port, either `port_resume_req` or `port_wakeup` starts resume signalling, and `pss` stays 1. A response tagged with a port whose `pss` is 1 is dropped.
- R6: After `port_rsm_done` during resume signalling, the port's `pss` stays 1 until the edge that samples the BLANK_TICKS-th later `frame_tick`. A tick in the same cycle as `port_rsm_done` is not counted.
- R7: A port's `pssc` goes to 1 in the same cycle that its `pss` falls to 0. A 1 on `pssc_clr` clears `pssc`. If a set and a clear occur in the same cycle, the set wins.
- R8: `irq` is 1 exactly when `int_en` is 1 and at least one `pssc` bit is 1.
- R9: `list_allow` equals `list_en` while `hc_state` is operational and is 0 otherwise, whether or not a window is open. The bits of both are: [0] periodic, [1] isochronous, [2] control, [3] bulk.
- R10: Each port has its own state and its own tick counter. Requests and strobes for one port leave the `pss` and `pssc` of every other port unchanged.
- R11: A response whose `rsp_port` is not below PORTS is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse every 1 ms frame |
| state_wr_valid | input | 1 | Software write of the controller state |
| state_wr_val | input | 2 | Controller state value to load |
| ctl_wakeup | input | 1 | Remote wakeup seen while the controller is suspended |
| ctl_rsm_done | input | 1 | Controller resume signalling finished |
| port_susp_req | input | PORTS | Per-port suspend request |
| port_resume_req | input | PORTS | Per-port resume request |
| port_wakeup | input | PORTS | Per-port remote wakeup |
| port_rsm_done | input | PORTS | Per-port resume signalling finished |
| pssc_clr | input | PORTS | Write-1-to-clear of the change bits |
| int_en | input | 1 | Global enable for the status change interrupt |
| list_en | input | 4 | List enables: periodic, isochronous, control, bulk |
| rsp_valid | input | 1 | Upstream response event |
| rsp_port | input | PW | Port that the response came through |
| hc_state | output | 2 | Current controller state |
| list_allow | output | 4 | Lists allowed to issue transactions |
| rsp_drop | output | 1 | Response is to be ignored |
| rsp_cc | output | 4 | Completion code for the response |
| pss | output | PORTS | Port suspend status |
| pssc | output | PORTS | Port suspend status change |
| irq | output | 1 | Root hub status change interrupt |

## Verification
The bench builds the block with PORTS=3 and BLANK_TICKS=3. Three ports is not a power of two, so the 2-bit port tag can hold the value 3, which matches no port and exercises the out-of-range drop. With three ports there are also at least two bystander ports, so independence can be checked while a third port walks through suspend and resume. A window of three ticks keeps each resume short enough that random traffic covers many complete windows, as well as windows cut short by state writes.

// File: rtl/prb_pkg.sv
package prb_pkg;
    typedef enum logic [1:0] {
        HC_RESET   = 2'b00,
        HC_RESUME  = 2'b01,
        HC_OPER    = 2'b10,
        HC_SUSPEND = 2'b11
    } hc_state_e;

    typedef enum logic [1:0] {
        PT_ACTIVE   = 2'b00,
        PT_SUSP     = 2'b01,
        PT_RESUMING = 2'b10,
        PT_BLANK    = 2'b11
    } port_state_e;

    localparam logic [3:0] CC_OK  = 4'h0;
    localparam logic [3:0] CC_DNR = 4'h5;
    localparam int         LIST_CNT = 4;
endpackage

// File: rtl/prb_ctl.sv
module prb_ctl
    import prb_pkg::*;
#(
    parameter int BLANK_TICKS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_tick,
    input  logic      state_wr_valid,
    input  logic [1:0] state_wr_val,
    input  logic      wakeup,
    input  logic      rsm_done,
    output hc_state_e state,
    output logic      blank
);
    localparam int CNT_W = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_TICKS - 1);

    typedef struct packed {
        hc_state_e        st;
        logic             blank;
        logic [CNT_W-1:0] cnt;
    } ctl_regs_t;

    ctl_regs_t ctl_d, ctl_q;
    hc_state_e wr_st;

    always_comb begin
        ctl_d = ctl_q;
        wr_st = hc_state_e'(state_wr_val);
        if (ctl_q.blank && frame_tick) begin
            if (ctl_q.cnt == LAST) begin
                ctl_d.blank = 1'b0;
                ctl_d.cnt   = '0;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
        if (state_wr_valid) begin
            ctl_d.st = wr_st;
            if (wr_st == HC_OPER) begin
                if (ctl_q.st == HC_RESUME) begin
                    ctl_d.blank = 1'b1;
                    ctl_d.cnt   = '0;
                end
            end else begin
                ctl_d.blank = 1'b0;
                ctl_d.cnt   = '0;
            end
        end else if (wakeup && ctl_q.st == HC_SUSPEND) begin
            ctl_d.st = HC_RESUME;
        end else if (rsm_done && ctl_q.st == HC_RESUME) begin
            ctl_d.st    = HC_OPER;
            ctl_d.blank = 1'b1;
            ctl_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: HC_RESET, blank: 1'b0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state = ctl_q.st;
    assign blank = ctl_q.blank;
endmodule

// File: rtl/prb_port.sv
module prb_port
    import prb_pkg::*;
#(
    parameter int BLANK_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic susp_req,
    input  logic resume_req,
    input  logic wakeup,
    input  logic rsm_done,
    input  logic pssc_clr,
    output logic active,
    output logic pssc
);
    localparam int CNT_W = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_TICKS - 1);

    typedef struct packed {
        port_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             pssc;
    } port_regs_t;

    port_regs_t pt_d, pt_q;
    logic       done_set;

    always_comb begin
        pt_d     = pt_q;
        done_set = 1'b0;
        case (pt_q.st)
            PT_ACTIVE: begin
                if (susp_req) pt_d.st = PT_SUSP;
            end
            PT_SUSP: begin
                if (resume_req || wakeup) pt_d.st = PT_RESUMING;
            end
            PT_RESUMING: begin
                if (rsm_done) begin
                    pt_d.st  = PT_BLANK;
                    pt_d.cnt = '0;
                end
            end
            PT_BLANK: begin
                if (frame_tick) begin
                    if (pt_q.cnt == LAST) begin
                        pt_d.st  = PT_ACTIVE;
                        pt_d.cnt = '0;
                        done_set = 1'b1;
                    end else begin
                        pt_d.cnt = pt_q.cnt + 1'b1;
                    end
                end
            end
            default: pt_d.st = PT_ACTIVE;
        endcase
        pt_d.pssc = done_set | (pt_q.pssc & ~pssc_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '{st: PT_ACTIVE, cnt: '0, pssc: 1'b0};
        end else begin
            pt_q <= pt_d;
        end
    end

    assign active = (pt_q.st == PT_ACTIVE);
    assign pssc   = pt_q.pssc;
endmodule

// File: rtl/prb_filter.sv
module prb_filter
    import prb_pkg::*;
#(
    parameter int PORTS = 2,
    parameter int PW    = 1
) (
    input  hc_state_e          state,
    input  logic               blank,
    input  logic [PORTS-1:0]   port_active,
    input  logic               rsp_valid,
    input  logic [PW-1:0]      rsp_port,
    input  logic [LIST_CNT-1:0] list_en,
    output logic               rsp_drop,
    output logic [3:0]         rsp_cc,
    output logic [LIST_CNT-1:0] list_allow
);
    logic port_ok;
    logic oper;

    always_comb begin
        port_ok = 1'b0;
        for (int i = 0; i < PORTS; i++) begin
            if (rsp_port == PW'(i)) port_ok = port_active[i];
        end
        oper       = (state == HC_OPER);
        rsp_drop   = rsp_valid && (!oper || blank || !port_ok);
        rsp_cc     = rsp_drop ? CC_DNR : CC_OK;
        list_allow = oper ? list_en : '0;
    end
endmodule

// File: rtl/port_resume_blank.sv
module port_resume_blank
    import prb_pkg::*;
#(
    parameter int PORTS       = 2,
    parameter int BLANK_TICKS = 3,
    parameter int PW          = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             state_wr_valid,
    input  logic [1:0]       state_wr_val,
    input  logic             ctl_wakeup,
    input  logic             ctl_rsm_done,
    input  logic [PORTS-1:0] port_susp_req,
    input  logic [PORTS-1:0] port_resume_req,
    input  logic [PORTS-1:0] port_wakeup,
    input  logic [PORTS-1:0] port_rsm_done,
    input  logic [PORTS-1:0] pssc_clr,
    input  logic             int_en,
    input  logic [3:0]       list_en,
    input  logic             rsp_valid,
    input  logic [PW-1:0]    rsp_port,
    output logic [1:0]       hc_state,
    output logic [3:0]       list_allow,
    output logic             rsp_drop,
    output logic [3:0]       rsp_cc,
    output logic [PORTS-1:0] pss,
    output logic [PORTS-1:0] pssc,
    output logic             irq
);
    hc_state_e        hc_st;
    logic             hc_blank;
    logic [PORTS-1:0] port_active;

    prb_ctl #(.BLANK_TICKS(BLANK_TICKS)) u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_tick     (frame_tick),
        .state_wr_valid (state_wr_valid),
        .state_wr_val   (state_wr_val),
        .wakeup         (ctl_wakeup),
        .rsm_done       (ctl_rsm_done),
        .state          (hc_st),
        .blank          (hc_blank)
    );

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        prb_port #(.BLANK_TICKS(BLANK_TICKS)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_tick (frame_tick),
            .susp_req   (port_susp_req[g]),
            .resume_req (port_resume_req[g]),
            .wakeup     (port_wakeup[g]),
            .rsm_done   (port_rsm_done[g]),
            .pssc_clr   (pssc_clr[g]),
            .active     (port_active[g]),
            .pssc       (pssc[g])
        );
    end

    prb_filter #(.PORTS(PORTS), .PW(PW)) u_filter (
        .state       (hc_st),
        .blank       (hc_blank),
        .port_active (port_active),
        .rsp_valid   (rsp_valid),
        .rsp_port    (rsp_port),
        .list_en     (list_en),
        .rsp_drop    (rsp_drop),
        .rsp_cc      (rsp_cc),
        .list_allow  (list_allow)
    );

    assign hc_state = hc_st;
    assign pss      = ~port_active;
    assign irq      = int_en & (|pssc);
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
    parameter int PORTS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             state_wr_valid,
    input logic             ctl_wakeup,
    input logic [PORTS-1:0] port_susp_req,
    input logic             int_en,
    input logic             rsp_valid,
    input logic             rsp_drop,
    input logic [3:0]       rsp_cc,
    input logic [1:0]       hc_state,
    input logic             hc_blank,
    input logic [3:0]       list_allow,
    input logic [PORTS-1:0] pss,
    input logic [PORTS-1:0] pssc,
    input logic             irq
);
    AST_DROP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_drop |-> rsp_cc == 4'h5); // R4
    AST_NOT_OPER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hc_state != 2'b10) |-> rsp_drop); // R4
    AST_BLANK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hc_blank) |-> rsp_drop); // R3
    AST_WAKE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_state == 2'b11 && ctl_wakeup && !state_wr_valid) |=> hc_state == 2'b01); // R2
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_en); // R8
    AST_LIST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_state != 2'b10) |-> list_allow == 4'b0000); // R9

    for (genvar g = 0; g < PORTS; g++) begin : g_chk
        AST_PSS_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pss[g]) |-> $past(frame_tick)); // R6
        AST_PSSC_WITH_PSS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pssc[g]) |-> $fell(pss[g])); // R7
        AST_PSS_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pss[g]) |-> $past(port_susp_req[g])); // R5
    end
endmodule

bind port_resume_blank prb_checker #(.PORTS(PORTS)) u_prb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_tick     (frame_tick),
    .state_wr_valid (state_wr_valid),
    .ctl_wakeup     (ctl_wakeup),
    .port_susp_req  (port_susp_req),
    .int_en         (int_en),
    .rsp_valid      (rsp_valid),
    .rsp_drop       (rsp_drop),
    .rsp_cc         (rsp_cc),
    .hc_state       (hc_state),
    .hc_blank       (hc_blank),
    .list_allow     (list_allow),
    .pss            (pss),
    .pssc           (pssc),
    .irq            (irq)
);

// File: tb/port_resume_blank_test.sv
module port_resume_blank_test;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 3;
    localparam int BT = 3;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick, state_wr_valid, ctl_wakeup, ctl_rsm_done, int_en, rsp_valid;
    logic [1:0] state_wr_val;
    logic [P-1:0] port_susp_req, port_resume_req, port_wakeup, port_rsm_done, pssc_clr;
    logic [3:0] list_en;
    logic [PW-1:0] rsp_port;
    logic [1:0] hc_state;
    logic [3:0] list_allow, rsp_cc;
    logic rsp_drop, irq;
    logic [P-1:0] pss, pssc;

    int checks = 0;
    int errors = 0;
    string drop_tag = "R4";

    // reference state: controller 0 reset,1 resume,2 oper,3 suspend; port 0 active,1 susp,2 resuming,3 blank
    int m_hc, m_hcnt;
    bit m_blank;
    int m_pst [P];
    int m_pcnt [P];
    bit m_pssc [P];

    always #(CLK_PERIOD/2) clk = ~clk;

    port_resume_blank #(.PORTS(P), .BLANK_TICKS(BT)) uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .state_wr_valid(state_wr_valid), .state_wr_val(state_wr_val),
        .ctl_wakeup(ctl_wakeup), .ctl_rsm_done(ctl_rsm_done),
        .port_susp_req(port_susp_req), .port_resume_req(port_resume_req),
        .port_wakeup(port_wakeup), .port_rsm_done(port_rsm_done),
        .pssc_clr(pssc_clr), .int_en(int_en), .list_en(list_en),
        .rsp_valid(rsp_valid), .rsp_port(rsp_port),
        .hc_state(hc_state), .list_allow(list_allow), .rsp_drop(rsp_drop),
        .rsp_cc(rsp_cc), .pss(pss), .pssc(pssc), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic bit exp_drop();
        if (!rsp_valid) return 1'b0;
        if (m_hc != 2 || m_blank) return 1'b1;
        if (int'(rsp_port) >= P) return 1'b1;
        return m_pst[rsp_port] != 0;
    endfunction

    function automatic bit any_pssc();
        bit a = 1'b0;
        for (int i = 0; i < P; i++) a |= m_pssc[i];
        return a;
    endfunction

    task automatic clear_in();
        frame_tick = 0; state_wr_valid = 0; state_wr_val = 0;
        ctl_wakeup = 0; ctl_rsm_done = 0;
        port_susp_req = 0; port_resume_req = 0; port_wakeup = 0;
        port_rsm_done = 0; pssc_clr = 0;
    endtask

    task automatic model_step();
        int nh = m_hc, nc = m_hcnt;
        bit nb = m_blank;
        if (m_blank && frame_tick) begin
            if (m_hcnt == BT-1) begin nb = 0; nc = 0; end else nc = m_hcnt + 1;
        end
        if (state_wr_valid) begin
            nh = int'(state_wr_val);
            if (nh == 2) begin
                if (m_hc == 1) begin nb = 1; nc = 0; end
            end else begin nb = 0; nc = 0; end
        end else if (ctl_wakeup && m_hc == 3) nh = 1;
        else if (ctl_rsm_done && m_hc == 1) begin nh = 2; nb = 1; nc = 0; end
        m_hc = nh; m_blank = nb; m_hcnt = nc;
        for (int i = 0; i < P; i++) begin
            bit setc = 1'b0;
            case (m_pst[i])
                0: if (port_susp_req[i]) m_pst[i] = 1;
                1: if (port_resume_req[i] || port_wakeup[i]) m_pst[i] = 2;
                2: if (port_rsm_done[i]) begin m_pst[i] = 3; m_pcnt[i] = 0; end
                default: if (frame_tick) begin
                    if (m_pcnt[i] == BT-1) begin m_pst[i] = 0; m_pcnt[i] = 0; setc = 1'b1; end
                    else m_pcnt[i]++;
                end
            endcase
            m_pssc[i] = setc | (m_pssc[i] & ~pssc_clr[i]);
        end
    endtask

    // called at a negedge with inputs applied; checks this cycle, then advances one clock
    task automatic run();
        bit ed;
        #1;
        chk("R2 hc_state", int'(hc_state), m_hc);
        for (int i = 0; i < P; i++) begin
            chk("R6 pss", int'(pss[i]), int'(m_pst[i] != 0));
            chk("R7 pssc", int'(pssc[i]), int'(m_pssc[i]));
        end
        chk("R8 irq", int'(irq), int'(int_en && any_pssc()));
        chk("R9 list_allow", int'(list_allow), (m_hc == 2) ? int'(list_en) : 0);
        ed = exp_drop();
        chk({drop_tag, " rsp_drop"}, int'(rsp_drop), int'(ed));
        chk("R4 rsp_cc", int'(rsp_cc), ed ? 5 : 0);
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit tick_last);
        for (int k = 0; k < n; k++) begin
            clear_in();
            frame_tick = tick_last && (k == n-1);
            run();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements got=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        clear_in(); int_en = 0; list_en = 4'hF; rsp_valid = 0; rsp_port = 0;
        m_hc = 0; m_hcnt = 0; m_blank = 0;
        for (int i = 0; i < P; i++) begin m_pst[i] = 0; m_pcnt[i] = 0; m_pssc[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset hc_state", int'(hc_state), 0);
        chk("R1 reset pss", int'(pss), 0);
        chk("R1 reset pssc", int'(pssc), 0);
        chk("R1 reset irq", int'(irq), 0);

        // R2: suspend, wakeup to resume, done to operational with window
        clear_in(); state_wr_valid = 1; state_wr_val = 2'b11; run();
        clear_in(); ctl_rsm_done = 1; run();
        chk("R2 done ignored outside resume", int'(hc_state), 3);
        clear_in(); ctl_wakeup = 1; run();
        chk("R2 wakeup to resume", int'(hc_state), 1);
        // R3: window opens, tick in the entry cycle is not counted
        drop_tag = "R3"; rsp_valid = 1; rsp_port = 0;
        clear_in(); ctl_rsm_done = 1; frame_tick = 1; run();
        chk("R2 resume to operational", int'(hc_state), 2);
        idle(3, 1'b1);
        idle(3, 1'b1);
        #1 chk("R3 still blanked before third tick", int'(rsp_drop), 1);
        chk("R9 lists open during window", int'(list_allow), 15);
        idle(2, 1'b1);
        #1 chk("R3 accepted after window", int'(rsp_drop), 0);
        chk("R4 ok code", int'(rsp_cc), 0);
        clear_in(); ctl_wakeup = 1; run();
        chk("R2 wakeup ignored when operational", int'(hc_state), 2);

        // R11: tag outside the port range
        drop_tag = "R11"; rsp_port = 2'd3; #1;
        chk("R11 out of range port dropped", int'(rsp_drop), 1);
        idle(1, 1'b0);

        // R5/R6/R7/R8/R10: port 1 suspend and resume
        drop_tag = "R5"; int_en = 1; rsp_port = 1;
        clear_in(); port_susp_req[1] = 1; run();
        chk("R5 pss set", int'(pss[1]), 1);
        chk("R10 port0 untouched", int'(pss[0]), 0);
        chk("R10 port2 untouched", int'(pss[2]), 0);
        #1 chk("R5 suspended port dropped", int'(rsp_drop), 1);
        clear_in(); port_wakeup[1] = 1; run();
        chk("R5 pss held while resuming", int'(pss[1]), 1);
        clear_in(); port_rsm_done[1] = 1; frame_tick = 1; run();
        idle(2, 1'b1); idle(2, 1'b1);
        chk("R6 pss held before last tick", int'(pss[1]), 1);
        idle(2, 1'b1);
        chk("R6 pss cleared after window", int'(pss[1]), 0);
        chk("R7 pssc raised", int'(pssc[1]), 1);
        chk("R8 irq raised", int'(irq), 1);
        chk("R10 port0 pssc untouched", int'(pssc[0]), 0);
        clear_in(); pssc_clr[1] = 1; run();
        chk("R7 pssc cleared", int'(pssc[1]), 0);
        chk("R8 irq dropped", int'(irq), 0);
        // R7: set wins over clear in the same cycle, port 0
        clear_in(); port_susp_req[0] = 1; run();
        clear_in(); port_resume_req[0] = 1; run();
        clear_in(); port_rsm_done[0] = 1; run();
        idle(1, 1'b1); idle(1, 1'b1);
        clear_in(); frame_tick = 1; pssc_clr[0] = 1; run();
        chk("R7 set beats clear", int'(pssc[0]), 1);
        chk("R10 port2 still active", int'(pss[2]), 0);

        // random traffic
        drop_tag = "R4";
        for (int n = 0; n < 4000; n++) begin
            int r;
            clear_in();
            frame_tick = ($urandom % 4) == 0;
            state_wr_valid = ($urandom % 60) == 0;
            r = $urandom % 8;
            state_wr_val = (r == 0) ? 2'b00 : (r < 3) ? 2'b11 : (r < 5) ? 2'b01 : 2'b10;
            ctl_wakeup = ($urandom % 10) == 0;
            ctl_rsm_done = ($urandom % 8) == 0;
            for (int i = 0; i < P; i++) begin
                port_susp_req[i]   = ($urandom % 20) == 0;
                port_resume_req[i] = ($urandom % 25) == 0;
                port_wakeup[i]     = ($urandom % 30) == 0;
                port_rsm_done[i]   = ($urandom % 6) == 0;
                pssc_clr[i]        = ($urandom % 8) == 0;
            end
            if (($urandom % 50) == 0) int_en = ~int_en;
            list_en = 4'($urandom);
            rsp_valid = ($urandom % 2) == 0;
            rsp_port = PW'($urandom);
            run();
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule